// File: doc/BRIEF.md
# Flash block-erase command sequencer

This block watches the stream of write strobes that a flash controller model receives from its host bus. It looks for the six-write unlock sequence that requests a block erase. The first five writes must carry fixed data values to fixed low addresses. The sixth write carries the erase opcode, and its address selects the block to erase. When that last write is accepted, the block raises a one-clock erase-start pulse and presents the chosen block index, so that the erase engine behind it can begin.

Only the low 16 address bits of the unlock writes are compared, and the upper bits are free. The block index comes from a parameterised slice of the sixth write's address. Any write that breaks the sequence sends the tracker back to the start. That write still counts as a fresh first write if it is itself a valid first write. While the erase engine reports busy, every write is ignored and the tracker stays at the start.

Top module: `erase_cmd_seq`

## Requirements
- R1: After reset, erase_start is 0, erase_blk is 0, and the sequencer expects write 1.
- R2: The six accepted writes, in order, are: data AAh to low address 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, and 50h to any address. If the block index (address bits [BLK_LSB +: BLK_W], by default bits 19:16) of the last write is below NUM_BLOCKS, erase_start is high in the clock cycle after that write and erase_blk equals the index.
- R3: Address bits above bit 15 have no effect on whether writes 1 to 5 match.
- R4: A write during steps 1 to 5 whose low address or data differs from the expected pair returns the sequencer to write 1, so that completing the remaining writes produces no pulse.
- R5: A mismatching write that is itself AAh to low 5555h is counted as write 1 of a new sequence.
- R6: A sixth write whose data is not 50h produces no pulse and returns the sequencer to write 1.
- R7: A sixth write of 50h whose block index is NUM_BLOCKS or more produces no pulse and returns the sequencer to write 1.
- R8: In any cycle where busy is high, a write is ignored, no pulse follows, and the sequencer returns to write 1.
- R9: erase_start lasts exactly one cycle, and erase_blk keeps its value until the next accepted erase.
- R10: Cycles with wr_en low do not change the sequence progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Erase engine busy; writes are ignored while high |
| erase_start | output | 1 | One-cycle request to start a block erase |
| erase_blk | output | BLK_W | Index of the block to erase, held after the pulse |

## Verification
Every result of this block is due exactly one clock after the write that causes it. The pulse and the block index are registered at the edge that accepts the sixth write, and a busy cycle or a mismatch takes effect at that same edge. The bench drives each write on a falling edge and compares erase_start and erase_blk on the next falling edge with a model that is updated from the requirements. As a result, each comparison falls one edge after its stimulus, and no other write has been accepted in between.

// File: rtl/erase_seq_pkg.sv
// Shared constants and types for the block-erase command sequencer.
// Assumes byte-wide write data and a 16-bit compared address field.
package erase_seq_pkg;
    localparam int MATCH_W = 16;
    localparam int DATA_W  = 8;

    localparam logic [MATCH_W-1:0] LO_ADDR_A = 16'h5555;
    localparam logic [MATCH_W-1:0] LO_ADDR_B = 16'h2AAA;

    localparam logic [DATA_W-1:0] D_UNLOCK_1 = 8'hAA;
    localparam logic [DATA_W-1:0] D_UNLOCK_2 = 8'h55;
    localparam logic [DATA_W-1:0] D_SETUP    = 8'h80;
    localparam logic [DATA_W-1:0] D_BLK_OP   = 8'h50;

    // Which write of the sequence is expected next.
    typedef enum logic [2:0] {
        ST_W1 = 3'd0,
        ST_W2 = 3'd1,
        ST_W3 = 3'd2,
        ST_W4 = 3'd3,
        ST_W5 = 3'd4,
        ST_W6 = 3'd5
    } seq_step_t;
endpackage

// File: rtl/wr_match.sv
// Decodes one write into pattern hits: which fixed (address, data) pairs of
// the unlock sequence it matches. Only the low MATCH_W address bits are
// looked at; the caller passes nothing else. Purely combinational.
module wr_match
    import erase_seq_pkg::*;
(
    input  logic [MATCH_W-1:0] lo_addr,
    input  logic [DATA_W-1:0]  data,
    output logic               hit_a_aa,
    output logic               hit_b_55,
    output logic               hit_a_80,
    output logic               hit_op
);
    logic at_a;
    logic at_b;

    // Address comparators shared by all patterns.
    always_comb begin
        at_a = (lo_addr == LO_ADDR_A);
        at_b = (lo_addr == LO_ADDR_B);
    end

    // Address-and-data pattern hits.
    always_comb begin
        hit_a_aa = at_a && (data == D_UNLOCK_1);
        hit_b_55 = at_b && (data == D_UNLOCK_2);
        hit_a_80 = at_a && (data == D_SETUP);
        hit_op   = (data == D_BLK_OP);
    end
endmodule

// File: rtl/step_fsm.sv
// Tracks progress through the six-write erase sequence. A mismatch restarts
// at write 1 (or write 2 if the bad write is itself a valid write 1). Busy
// clears progress and blocks writes. Raises 'fire' combinationally when the
// sixth write is accepted with an in-range block.
module step_fsm
    import erase_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      busy,
    input  logic      hit_a_aa,
    input  logic      hit_b_55,
    input  logic      hit_a_80,
    input  logic      hit_op,
    input  logic      blk_ok,
    output seq_step_t step,
    output logic      fire
);
    seq_step_t step_nx;
    logic      exp_hit;
    logic      take;

    // Select the pattern that the current step expects.
    always_comb begin
        unique case (step)
            ST_W1:   exp_hit = hit_a_aa;
            ST_W2:   exp_hit = hit_b_55;
            ST_W3:   exp_hit = hit_a_80;
            ST_W4:   exp_hit = hit_a_aa;
            ST_W5:   exp_hit = hit_b_55;
            default: exp_hit = hit_op;
        endcase
    end

    // Next-step decision and the final-write accept.
    always_comb begin
        take    = wr_en && !busy;
        fire    = take && (step == ST_W6) && hit_op && blk_ok;
        step_nx = step;
        if (busy) begin
            step_nx = ST_W1;
        end else if (wr_en) begin
            if (step == ST_W6 && hit_op) begin
                step_nx = ST_W1;
            end else if (exp_hit) begin
                step_nx = seq_step_t'(3'(step) + 3'd1);
            end else if (hit_a_aa) begin
                step_nx = ST_W2;
            end else begin
                step_nx = ST_W1;
            end
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= ST_W1;
        else        step <= step_nx;
    end

    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (step == ST_W1));                                   // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !busy) |=> $stable(step));                        // R10
    AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (3'(step) <= 3'(ST_W6)));                                    // R2
endmodule

// File: rtl/blk_capture.sv
// Checks the block index of the sixth write against the configured block
// count and registers the erase-start pulse with the latched index.
// Assumes 'fire' is high for at most one cycle per accepted sequence.
module blk_capture #(
    parameter int BLK_W      = 4,
    parameter int NUM_BLOCKS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] idx,
    input  logic             fire,
    output logic             blk_ok,
    output logic             erase_start,
    output logic [BLK_W-1:0] erase_blk
);
    localparam int unsigned LIMIT = NUM_BLOCKS;

    // Range check of the candidate block index.
    always_comb blk_ok = (32'(idx) < LIMIT);

    // Pulse and index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_start <= 1'b0;
            erase_blk   <= '0;
        end else begin
            erase_start <= fire;
            if (fire) erase_blk <= idx;
        end
    end

    AST_START_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> (32'(erase_blk) < LIMIT));                   // R7
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);                               // R9
    AST_BLK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> $stable(erase_blk));                         // R9
endmodule

// File: rtl/erase_cmd_seq.sv
// Block-erase command sequencer top. Takes clean single-cycle write strobes,
// recognises the six-write erase sequence on the low 16 address bits and
// data, and emits a one-cycle erase-start pulse with the block index taken
// from wr_addr[BLK_LSB +: BLK_W] of the sixth write.
module erase_cmd_seq
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BLK_LSB    = 16,
    parameter int BLK_W      = 4,
    parameter int NUM_BLOCKS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output logic              erase_start,
    output logic [BLK_W-1:0]  erase_blk
);
    logic      hit_a_aa, hit_b_55, hit_a_80, hit_op;
    logic      blk_ok, fire;
    seq_step_t step;
    logic      unused_addr;

    // Remaining address bits are don't-care for this block.
    assign unused_addr = ^wr_addr;

    wr_match u_match (
        .lo_addr  (wr_addr[MATCH_W-1:0]),
        .data     (wr_data),
        .hit_a_aa (hit_a_aa),
        .hit_b_55 (hit_b_55),
        .hit_a_80 (hit_a_80),
        .hit_op   (hit_op)
    );

    step_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .busy     (busy),
        .hit_a_aa (hit_a_aa),
        .hit_b_55 (hit_b_55),
        .hit_a_80 (hit_a_80),
        .hit_op   (hit_op),
        .blk_ok   (blk_ok),
        .step     (step),
        .fire     (fire)
    );

    blk_capture #(
        .BLK_W      (BLK_W),
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx         (wr_addr[BLK_LSB +: BLK_W]),
        .fire        (fire),
        .blk_ok      (blk_ok),
        .erase_start (erase_start),
        .erase_blk   (erase_blk)
    );

    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !erase_start);                                      // R8
    AST_START_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> $past(wr_en && !busy));                      // R2
endmodule

// File: tb/sim_erase_cmd_seq.sv
// Self-checking bench: directed corner cases plus seeded random writes,
// compared one clock after each stimulus with a requirement-level model.
module sim_erase_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int BLK_LSB    = 16;
    localparam int BLK_W      = 4;
    localparam int NUM_BLOCKS = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              busy = 1'b0;
    logic              erase_start;
    logic [BLK_W-1:0]  erase_blk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Model state: index of the next expected write (0..5).
    int               m_step = 0;
    bit               exp_start = 0;
    logic [BLK_W-1:0] exp_blk = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    erase_cmd_seq #(
        .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .BLK_W(BLK_W), .NUM_BLOCKS(NUM_BLOCKS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy),
        .erase_start(erase_start), .erase_blk(erase_blk)
    );

    function automatic logic [15:0] step_lo(int s);
        return (s == 1 || s == 4) ? 16'h2AAA : 16'h5555;
    endfunction

    function automatic logic [7:0] step_dat(int s);
        case (s)
            0, 3:    return 8'hAA;
            1, 4:    return 8'h55;
            2:       return 8'h80;
            default: return 8'h50;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(logic [15:0] hi, logic [15:0] lo);
        return {hi, lo};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // Requirement-level model of one cycle of stimulus.
    task automatic model(bit we, logic [ADDR_W-1:0] a, logic [7:0] d, bit b);
        bit w1;
        logic [BLK_W-1:0] ix;
        w1 = (a[15:0] == 16'h5555) && (d == 8'hAA);
        exp_start = 0;
        if (b) m_step = 0;
        else if (we) begin
            if (m_step == 5) begin
                if (d == 8'h50) begin
                    ix = a[BLK_LSB +: BLK_W];
                    if (int'(ix) < NUM_BLOCKS) begin
                        exp_start = 1;
                        exp_blk   = ix;
                    end
                    m_step = 0;
                end else m_step = w1 ? 1 : 0;
            end else if (a[15:0] == step_lo(m_step) && d == step_dat(m_step))
                m_step++;
            else m_step = w1 ? 1 : 0;
        end
    endtask

    // One cycle: drive on falling edge, compare on the next falling edge.
    task automatic op(bit we, logic [ADDR_W-1:0] a, logic [7:0] d, bit b, string req);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; busy = b;
        model(we, a, d, b);
        @(negedge clk);
        #1;
        check(erase_start == exp_start, req, "erase_start", int'(erase_start), int'(exp_start));
        check(erase_blk == exp_blk, req, "erase_blk", int'(erase_blk), int'(exp_blk));
        wr_en = 0; busy = 0;
    endtask

    task automatic wr_step(int s, logic [15:0] hi, string req);
        op(1, mk_addr(hi, step_lo(s)), step_dat(s), 0, req);
    endtask

    task automatic full_seq(logic [BLK_W-1:0] blk, string req);
        for (int s = 0; s < 5; s++) wr_step(s, 16'($urandom), req);
        op(1, {12'($urandom), blk, 16'($urandom)}, 8'h50, 0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        check(erase_start == 0, "R1", "erase_start", int'(erase_start), 0);
        check(erase_blk == 0, "R1", "erase_blk", int'(erase_blk), 0);

        // R2: clean sequence to block 5
        full_seq(4'd5, "R2");
        check(exp_start == 1, "R2", "model pulse", int'(exp_start), 1);
        // R9: pulse gone next cycle, index held
        op(0, '0, '0, 0, "R9");
        op(0, '0, '0, 0, "R9");

        // R3: upper bits all ones / varied, last in-range block
        for (int s = 0; s < 5; s++) wr_step(s, 16'hFFFF - 16'(s), "R3");
        op(1, {12'hABC, 4'd11, 16'h1234}, 8'h50, 0, "R3");

        // R4: wrong data on write 3, remaining writes do not start an erase
        wr_step(0, 16'h0, "R4"); wr_step(1, 16'h0, "R4");
        op(1, mk_addr(16'h0, 16'h5555), 8'h90, 0, "R4");
        for (int s = 3; s < 5; s++) wr_step(s, 16'h0, "R4");
        op(1, {12'h0, 4'd2, 16'h0}, 8'h50, 0, "R4");
        // R4: wrong address on write 2
        wr_step(0, 16'h0, "R4");
        op(1, mk_addr(16'h0, 16'h2AAB), 8'h55, 0, "R4");
        for (int s = 2; s < 5; s++) wr_step(s, 16'h0, "R4");
        op(1, {12'h0, 4'd3, 16'h0}, 8'h50, 0, "R4");

        // R5: AAh/5555h in place of write 3 restarts as write 1
        wr_step(0, 16'h7, "R5"); wr_step(1, 16'h7, "R5"); wr_step(0, 16'h7, "R5");
        for (int s = 1; s < 5; s++) wr_step(s, 16'h7, "R5");
        op(1, {12'h0, 4'd7, 16'h0}, 8'h50, 0, "R5");

        // R6: wrong opcode on write 6, then a lone opcode
        for (int s = 0; s < 5; s++) wr_step(s, 16'h0, "R6");
        op(1, {12'h0, 4'd1, 16'h0}, 8'h30, 0, "R6");
        op(1, {12'h0, 4'd1, 16'h0}, 8'h50, 0, "R6");

        // R7: out-of-range blocks 12 and 15
        full_seq(4'd12, "R7");
        full_seq(4'd15, "R7");

        // R8: busy in the middle, and busy on write 6
        wr_step(0, 16'h0, "R8"); wr_step(1, 16'h0, "R8"); wr_step(2, 16'h0, "R8");
        op(1, mk_addr(16'h0, 16'h5555), 8'hAA, 1, "R8");
        wr_step(4, 16'h0, "R8");
        op(1, {12'h0, 4'd4, 16'h0}, 8'h50, 0, "R8");
        for (int s = 0; s < 5; s++) wr_step(s, 16'h0, "R8");
        op(1, {12'h0, 4'd6, 16'h0}, 8'h50, 1, "R8");

        // R10: idle gaps between writes keep progress
        for (int s = 0; s < 5; s++) begin
            wr_step(s, 16'h0, "R10");
            repeat (s + 1) op(0, 32'($urandom), 8'($urandom), 0, "R10");
        end
        op(1, {12'h0, 4'd9, 16'h0}, 8'h50, 0, "R10");

        // Random mix: mostly correct next writes, some corruption, busy and idles.
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [ADDR_W-1:0] a;
            logic [7:0] d;
            r = int'($urandom_range(0, 99));
            a = {16'($urandom), step_lo(m_step)};
            d = step_dat(m_step);
            if (m_step == 5) a[BLK_LSB +: BLK_W] = 4'($urandom_range(0, 13));
            if (r < 4)       op(1, a, d, 1, "R8");
            else if (r < 12) op(0, a, d, 0, "R10");
            else if (r < 18) op(1, a, 8'($urandom), 0, "R4");
            else if (r < 22) op(1, mk_addr(16'($urandom), 16'h5555), 8'hAA, 0, "R5");
            else             op(1, a, d, 0, "R2");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule